// File: doc/BRIEF.md
# Four-Register 8-bit Multicycle Processor

This block is a very small processor core with four 8-bit general registers, one 16-byte memory shared by code and data, an instruction pointer and two result flags (zero and negative). Every instruction takes four clock cycles, one for each phase: the fetch phase reads the two instruction bytes and advances the pointer, the decode phase splits the fields, the execute phase reads operands and runs the adder/subtractor, and the writeback phase commits the result. The supported operations are loading an immediate, copying one register to another, storing a register to memory, adding, subtracting and an unconditional jump. A dedicated opcode stops the core.

A program is written into memory through a byte-wide load port while reset is held low. When reset is released the core starts at address 0 and runs until it reaches the stop opcode. The registers, pointer and flags are visible at all times on debug outputs. One memory byte, chosen by a debug address, can be read at any time.

Top module: `quad_reg_cpu`

## Requirements
- R1: An instruction is two bytes at consecutive addresses. Byte 0 is {opcode[7:4], dst[3:2], src[1:0]} with register select A=0, B=1, C=2, D=3, and byte 1 is an immediate or memory address. The four registers are 8 bits wide.
- R2: Opcode 1 writes byte 1 into dst. Opcode 2 copies src into dst.
- R3: Opcode 3 writes src into the memory byte at the address in the low 4 bits of byte 1, and the stored value can be read on the debug memory port.
- R4: Opcode 4 (dst+src) and opcode 5 (dst-src) write the result modulo 256 into dst, set the zero flag when that result is 0, and set the negative flag to bit 7 of that result.
- R5: All opcodes other than 4 and 5 leave both flags unchanged. Opcodes 0 and 7 to 14 change nothing except the pointer advance.
- R6: Opcode 6 loads the instruction pointer from the low 4 bits of byte 1.
- R7: Each instruction runs through fetch, decode, execute and writeback on four consecutive clock edges. The pointer increases by 2 modulo 16 on the fetch edge, and a register result appears after the fourth edge.
- R8: Reset clears the registers, the flags, the pointer and the halt output, and keeps memory contents. The load port writes memory only while reset is low and is ignored otherwise.
- R9: Opcode 15 raises the halt output. From then until reset, the registers, flags and pointer do not change.
- R10: The program "load A with 5, load B with 3, A=A+B, store A to address 0, A=A-B, stop" ends with A=5, B=3, memory byte 0 equal to 8, and both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Program load strobe, honoured only during reset |
| load_addr | input | 4 | Program load byte address |
| load_data | input | 8 | Program load byte value |
| dbg_mem_addr | input | 4 | Debug memory read address |
| dbg_mem_data | output | 8 | Memory byte at dbg_mem_addr |
| halted | output | 1 | High once the stop opcode has retired |
| dbg_reg_a | output | 8 | Register A |
| dbg_reg_b | output | 8 | Register B |
| dbg_reg_c | output | 8 | Register C |
| dbg_reg_d | output | 8 | Register D |
| dbg_ip | output | 4 | Instruction pointer |
| dbg_zero | output | 1 | Zero flag |
| dbg_neg | output | 1 | Negative flag |

## Verification
The assertions assume that the program is loaded only while reset is low and that reset is released between clock edges, so that the first sampled high reset sees the cleared state. They place no limit on what the program contains, because every byte value decodes to a defined action. The stimulus loads all sixteen bytes before each release. The self-modifying case writes memory only through the core's own store, and the load port is driven after reset only to show that it has no effect.

// File: rtl/qcpu_pkg.sv
package qcpu_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int MEM_DEPTH = 1 << ADDR_W;
    localparam int NUM_REGS  = 4;
    localparam int SEL_W     = $clog2(NUM_REGS);
    localparam int OP_W      = 4;

    localparam logic [OP_W-1:0] OP_NOP   = 4'h0;
    localparam logic [OP_W-1:0] OP_MOVI  = 4'h1;
    localparam logic [OP_W-1:0] OP_MOVR  = 4'h2;
    localparam logic [OP_W-1:0] OP_STORE = 4'h3;
    localparam logic [OP_W-1:0] OP_ADD   = 4'h4;
    localparam logic [OP_W-1:0] OP_SUB   = 4'h5;
    localparam logic [OP_W-1:0] OP_JMP   = 4'h6;
    localparam logic [OP_W-1:0] OP_HALT  = 4'hF;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EXEC   = 3'd2,
        PH_WB     = 3'd3,
        PH_HALT   = 3'd4
    } phase_t;

    typedef struct packed {
        phase_t              phase;
        logic [ADDR_W-1:0]   ip;
        logic [DATA_W-1:0]   ir_hi;
        logic [DATA_W-1:0]   ir_lo;
        logic [OP_W-1:0]     op;
        logic [SEL_W-1:0]    dst;
        logic [SEL_W-1:0]    src;
        logic [DATA_W-1:0]   imm;
        logic [DATA_W-1:0]   opb;
        logic [DATA_W-1:0]   res;
        logic                res_z;
        logic                res_n;
        logic                zf;
        logic                nf;
    } core_t;

endpackage

// File: rtl/qcpu_mem.sv
module qcpu_mem #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr0,
    output logic [W-1:0]  rdata0,
    input  logic [AW-1:0] raddr1,
    output logic [W-1:0]  rdata1,
    input  logic [AW-1:0] raddr2,
    output logic [W-1:0]  rdata2
);

    logic [W-1:0] cells [DEPTH];

    // No reset: contents are loaded before the core runs and survive reset.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata0 = cells[raddr0];
    assign rdata1 = cells[raddr1];
    assign rdata2 = cells[raddr2];

endmodule

// File: rtl/qcpu_regfile.sv
module qcpu_regfile #(
    parameter int W  = 8,
    parameter int N  = 4,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [SW-1:0] raddr0,
    output logic [W-1:0]  rdata0,
    input  logic [SW-1:0] raddr1,
    output logic [W-1:0]  rdata1,
    output logic [N*W-1:0] dbg_flat
);

    logic [W-1:0] regs_q [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (we && (waddr == SW'(i))) begin
                regs_q[i] <= wdata;
            end
        end
        assign dbg_flat[i*W +: W] = regs_q[i];
    end

    assign rdata0 = regs_q[raddr0];
    assign rdata1 = regs_q[raddr1];

endmodule

// File: rtl/qcpu_alu.sv
module qcpu_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y,
    output logic         zero,
    output logic         neg
);

    always_comb begin
        y    = sub ? (a - b) : (a + b);
        zero = (y == '0);
        neg  = y[W-1];
    end

endmodule

// File: rtl/quad_reg_cpu.sv
module quad_reg_cpu
    import qcpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [ADDR_W-1:0] dbg_mem_addr,
    output logic [DATA_W-1:0] dbg_mem_data,
    output logic              halted,
    output logic [DATA_W-1:0] dbg_reg_a,
    output logic [DATA_W-1:0] dbg_reg_b,
    output logic [DATA_W-1:0] dbg_reg_c,
    output logic [DATA_W-1:0] dbg_reg_d,
    output logic [ADDR_W-1:0] dbg_ip,
    output logic              dbg_zero,
    output logic              dbg_neg
);

    localparam logic [ADDR_W-1:0] IP_STEP  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] IP_NEXTB = ADDR_W'(1);
    localparam core_t CORE_RESET = '0;

    core_t c_q, c_d;

    // register file hookup
    logic              rf_we;
    logic [SEL_W-1:0]  rf_waddr;
    logic [DATA_W-1:0] rf_wdata;
    logic [DATA_W-1:0] rf_rd_dst, rf_rd_src;
    logic [NUM_REGS*DATA_W-1:0] rf_flat;

    // memory hookup
    logic              cpu_mem_we;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rd_hi, mem_rd_lo;

    // ALU hookup
    logic [DATA_W-1:0] alu_y;
    logic              alu_z, alu_n;

    // observation points for the checker
    logic              fetch_fire;
    logic              wb_fire;

    qcpu_regfile #(.W(DATA_W), .N(NUM_REGS)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (rf_we),
        .waddr    (rf_waddr),
        .wdata    (rf_wdata),
        .raddr0   (c_q.dst),
        .rdata0   (rf_rd_dst),
        .raddr1   (c_q.src),
        .rdata1   (rf_rd_src),
        .dbg_flat (rf_flat)
    );

    // While reset is low the load port owns the write side; afterwards only stores.
    always_comb begin
        if (!rst_n) begin
            mem_we    = load_en;
            mem_waddr = load_addr;
            mem_wdata = load_data;
        end else begin
            mem_we    = cpu_mem_we;
            mem_waddr = c_q.imm[ADDR_W-1:0];
            mem_wdata = c_q.opb;
        end
    end

    qcpu_mem #(.W(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
        .clk    (clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .raddr0 (c_q.ip),
        .rdata0 (mem_rd_hi),
        .raddr1 (c_q.ip + IP_NEXTB),
        .rdata1 (mem_rd_lo),
        .raddr2 (dbg_mem_addr),
        .rdata2 (dbg_mem_data)
    );

    qcpu_alu #(.W(DATA_W)) u_alu (
        .a    (rf_rd_dst),
        .b    (rf_rd_src),
        .sub  (c_q.op == OP_SUB),
        .y    (alu_y),
        .zero (alu_z),
        .neg  (alu_n)
    );

    always_comb begin
        c_d        = c_q;
        rf_we      = 1'b0;
        rf_waddr   = c_q.dst;
        rf_wdata   = c_q.res;
        cpu_mem_we = 1'b0;

        unique case (c_q.phase)
            PH_FETCH: begin
                c_d.ir_hi = mem_rd_hi;
                c_d.ir_lo = mem_rd_lo;
                c_d.ip    = c_q.ip + IP_STEP;
                c_d.phase = PH_DECODE;
            end
            PH_DECODE: begin
                c_d.op    = c_q.ir_hi[DATA_W-1 -: OP_W];
                c_d.dst   = c_q.ir_hi[2*SEL_W-1 -: SEL_W];
                c_d.src   = c_q.ir_hi[SEL_W-1:0];
                c_d.imm   = c_q.ir_lo;
                c_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                c_d.opb   = rf_rd_src;
                c_d.res   = alu_y;
                c_d.res_z = alu_z;
                c_d.res_n = alu_n;
                c_d.phase = PH_WB;
            end
            PH_WB: begin
                c_d.phase = PH_FETCH;
                case (c_q.op)
                    OP_MOVI: begin
                        rf_we    = 1'b1;
                        rf_wdata = c_q.imm;
                    end
                    OP_MOVR: begin
                        rf_we    = 1'b1;
                        rf_wdata = c_q.opb;
                    end
                    OP_STORE: begin
                        cpu_mem_we = 1'b1;
                    end
                    OP_ADD, OP_SUB: begin
                        rf_we    = 1'b1;
                        rf_wdata = c_q.res;
                        c_d.zf   = c_q.res_z;
                        c_d.nf   = c_q.res_n;
                    end
                    OP_JMP: begin
                        c_d.ip = c_q.imm[ADDR_W-1:0];
                    end
                    OP_HALT: begin
                        c_d.phase = PH_HALT;
                    end
                    default: begin
                        c_d.phase = PH_FETCH;
                    end
                endcase
            end
            PH_HALT: begin
                c_d.phase = PH_HALT;
            end
            default: begin
                c_d.phase = PH_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= CORE_RESET;
        end else begin
            c_q <= c_d;
        end
    end

    assign halted     = (c_q.phase == PH_HALT);
    assign dbg_ip     = c_q.ip;
    assign dbg_zero   = c_q.zf;
    assign dbg_neg    = c_q.nf;
    assign dbg_reg_a  = rf_flat[0*DATA_W +: DATA_W];
    assign dbg_reg_b  = rf_flat[1*DATA_W +: DATA_W];
    assign dbg_reg_c  = rf_flat[2*DATA_W +: DATA_W];
    assign dbg_reg_d  = rf_flat[3*DATA_W +: DATA_W];
    assign fetch_fire = (c_q.phase == PH_FETCH);
    assign wb_fire    = (c_q.phase == PH_WB);

endmodule

// File: rtl/qcpu_checker.sv
module qcpu_checker
    import qcpu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              halted,
    input logic              fetch_fire,
    input logic              wb_fire,
    input logic [OP_W-1:0]   wb_op,
    input logic [SEL_W-1:0]  wb_dst,
    input logic [ADDR_W-1:0] wb_tgt,
    input logic [ADDR_W-1:0] dbg_ip,
    input logic [DATA_W-1:0] reg_a,
    input logic [DATA_W-1:0] reg_b,
    input logic [DATA_W-1:0] reg_c,
    input logic [DATA_W-1:0] reg_d,
    input logic              dbg_zero,
    input logic              dbg_neg
);

    logic wb_arith;
    assign wb_arith = wb_fire && ((wb_op == OP_ADD) || (wb_op == OP_SUB));

    function automatic logic [DATA_W-1:0] pick(input logic [SEL_W-1:0] s,
                                               input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b,
                                               input logic [DATA_W-1:0] c,
                                               input logic [DATA_W-1:0] d);
        case (s)
            2'd0:    return a;
            2'd1:    return b;
            2'd2:    return c;
            default: return d;
        endcase
    endfunction

    assert_fetch_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_fire |=> (dbg_ip == $past(dbg_ip) + ADDR_W'(2)));

    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_fire && !wb_arith) |=> ($stable(dbg_zero) && $stable(dbg_neg)));

    assert_flags_follow_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_arith |=> ((dbg_neg == pick($past(wb_dst), reg_a, reg_b, reg_c, reg_d)[DATA_W-1]) &&
                      (dbg_zero == (pick($past(wb_dst), reg_a, reg_b, reg_c, reg_d) == '0))));

    assert_jump_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_fire && (wb_op == OP_JMP)) |=> (dbg_ip == $past(wb_tgt)));

    assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(dbg_ip) && $stable(reg_a) && $stable(reg_b) &&
                    $stable(reg_c) && $stable(reg_d) && $stable(dbg_zero) && $stable(dbg_neg)));

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dbg_ip == '0 && !halted && !dbg_zero && !dbg_neg &&
                          reg_a == '0 && reg_b == '0 && reg_c == '0 && reg_d == '0));

endmodule

bind quad_reg_cpu qcpu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halted     (halted),
    .fetch_fire (fetch_fire),
    .wb_fire    (wb_fire),
    .wb_op      (c_q.op),
    .wb_dst     (c_q.dst),
    .wb_tgt     (c_q.imm[3:0]),
    .dbg_ip     (dbg_ip),
    .reg_a      (dbg_reg_a),
    .reg_b      (dbg_reg_b),
    .reg_c      (dbg_reg_c),
    .reg_d      (dbg_reg_d),
    .dbg_zero   (dbg_zero),
    .dbg_neg    (dbg_neg)
);

// File: tb/quad_reg_cpu_tb.sv
module quad_reg_cpu_tb;

    localparam int NV = 6;
    localparam int WATCHDOG = 150000;

    // Programs: byte 0 is the leftmost byte of each literal.
    localparam logic [127:0] PROGS [NV] = '{
        128'h1005_1403_4100_3000_5100_F000_0000_0000, // R10 reference program
        128'h1807_1C07_5B00_1009_F000_0000_0000_0000, // zero result, then MOV keeps Z
        128'h1003_1405_5100_2C00_4000_F000_0000_0000, // borrow, copy, add wrap, N set
        128'h10FF_7F00_1401_4100_F000_0000_0000_0000, // unused opcode, 255+1 -> 0
        128'h1001_6006_10EE_2800_F000_0000_0000_0000, // jump over a load
        128'h600C_0000_0000_0000_0000_0000_1CF0_3300  // ip wrap, self-modifying stop
    };
    localparam logic [31:0] EXP_REGS [NV] = '{
        32'h05_03_00_00, 32'h09_00_00_07, 32'hFC_05_00_FE,
        32'h00_01_00_00, 32'h01_00_01_00, 32'h00_00_00_F0
    };
    localparam logic [1:0] EXP_ZN [NV] = '{2'b00, 2'b10, 2'b01, 2'b10, 2'b00, 2'b00};
    localparam logic [3:0] EXP_IP [NV] = '{4'd12, 4'd10, 4'd12, 4'd10, 4'd10, 4'd2};
    localparam string V_REQ [NV] = '{"R10", "R5", "R4", "R5", "R6", "R7"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic [3:0] dbg_mem_addr = '0;
    logic [7:0] dbg_mem_data;
    logic       halted;
    logic [7:0] dbg_reg_a, dbg_reg_b, dbg_reg_c, dbg_reg_d;
    logic [3:0] dbg_ip;
    logic       dbg_zero, dbg_neg;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    quad_reg_cpu u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_en      (load_en),
        .load_addr    (load_addr),
        .load_data    (load_data),
        .dbg_mem_addr (dbg_mem_addr),
        .dbg_mem_data (dbg_mem_data),
        .halted       (halted),
        .dbg_reg_a    (dbg_reg_a),
        .dbg_reg_b    (dbg_reg_b),
        .dbg_reg_c    (dbg_reg_c),
        .dbg_reg_d    (dbg_reg_d),
        .dbg_ip       (dbg_ip),
        .dbg_zero     (dbg_zero),
        .dbg_neg      (dbg_neg)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load_prog(input logic [127:0] img);
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_addr = 4'(i);
            load_data = img[8*(15-i) +: 8];
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run_to_halt();
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (halted) break;
        end
    endtask

    initial begin
        // Reset state (R8)
        repeat (3) @(negedge clk);
        check("R8", "halted in reset", 32'(halted), 32'd0);
        check("R8", "ip in reset", 32'(dbg_ip), 32'd0);
        check("R8", "flags in reset", {30'd0, dbg_zero, dbg_neg}, 32'd0);

        // Vector table walk (R1, R2, R4, R5, R6, R7, R10)
        for (int v = 0; v < NV; v++) begin
            load_prog(PROGS[v]);
            run_to_halt();
            check(V_REQ[v], "halted", 32'(halted), 32'd1);
            check("R1", "registers A,B,C,D",
                  {dbg_reg_a, dbg_reg_b, dbg_reg_c, dbg_reg_d}, EXP_REGS[v]);
            check(V_REQ[v], "flags Z,N", {30'd0, dbg_zero, dbg_neg}, {30'd0, EXP_ZN[v]});
            check(V_REQ[v], "final ip", 32'(dbg_ip), 32'(EXP_IP[v]));
        end

        // Directed: reset clears registers left by the last program (R8)
        load_prog(PROGS[0]);
        check("R8", "registers cleared in reset",
              {dbg_reg_a, dbg_reg_b, dbg_reg_c, dbg_reg_d}, 32'd0);

        // Directed: phase timing (R7, R2)
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", "ip after fetch edge", 32'(dbg_ip), 32'd2);
        @(negedge clk);
        @(negedge clk);
        check("R7", "A before writeback edge", 32'(dbg_reg_a), 32'd0);
        @(negedge clk);
        check("R2", "A after fourth edge", 32'(dbg_reg_a), 32'd5);
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (halted) break;
        end

        // Directed: stored byte and untouched neighbour (R3, R10)
        dbg_mem_addr = 4'd0;
        #1;
        check("R3", "memory byte 0 after store", 32'(dbg_mem_data), 32'h08);
        dbg_mem_addr = 4'd1;
        #1;
        check("R3", "memory byte 1 unchanged", 32'(dbg_mem_data), 32'h05);

        // Directed: load port ignored while running (R8)
        @(negedge clk);
        load_en   = 1'b1;
        load_addr = 4'd0;
        load_data = 8'h55;
        @(negedge clk);
        @(negedge clk);
        load_en = 1'b0;
        dbg_mem_addr = 4'd0;
        #1;
        check("R8", "load ignored out of reset", 32'(dbg_mem_data), 32'h08);

        // Directed: halt keeps state frozen (R9)
        repeat (20) @(negedge clk);
        check("R9", "halted stays high", 32'(halted), 32'd1);
        check("R9", "ip frozen", 32'(dbg_ip), 32'd12);
        check("R9", "A frozen", 32'(dbg_reg_a), 32'd5);

        // Directed: memory retained through reset (R8)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R8", "memory kept over reset", 32'(dbg_mem_data), 32'h08);
        check("R8", "halt cleared by reset", 32'(halted), 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule